// File: doc/BRIEF.md
# Register Alias Table Renamer

This block is the rename stage of an out-of-order core. It keeps, for every architectural register, a record of where the newest value of that register will come from. The value is either already in the committed register file, or it is still pending in a reorder-buffer slot. The physical tag of a renamed value is simply the reorder-buffer slot number assigned to the op that produces it.

Each cycle, a group of up to `LANES` ops is presented in program order. For every source operand, the block returns a location flag and a tag. Each destination is given the next reorder-buffer slot, counted from `alloc_base` across the valid lanes. A source that names a register written by an earlier op of the same group takes that op's new tag instead of the table contents. The table is written at the clock edge.

Retiring ops return a mapping to the committed file, but only while the entry still names the retiring slot. A flush returns every entry to the committed file in a single cycle. Lookups and destination tags are combinational from the inputs and from the table state held at the start of the cycle.

Top module: `reg_alias_renamer`

## Requirements
- R1: After reset, every architectural register maps to the committed file, so every source lookup reports location flag 0.
- R2: A source with no earlier writer in its own group returns the table entry for that register. Location flag 1 means the value is pending in the reorder buffer, and then the tag gives the slot number. Location flag 0 means the committed file.
- R3: The destination tag of valid lane i equals `alloc_base` plus the number of valid lanes below i, modulo `ROB_DEPTH`. Lanes are numbered from 0, oldest first.
- R4: A source that matches the destination of an earlier valid lane with destination enable in the same group reports flag 1 and that lane's new tag. The latest such lane wins.
- R5: After the clock edge, each register written by the group maps to flag 1 with the tag of the last lane that wrote it. A later group therefore sees that tag.
- R6: A lane with `in_valid` low, or with `in_dst_en` low, neither changes the table nor supplies a tag to other lanes.
- R7: A retire port with `ret_valid` set clears the flag of `ret_arch` only when the entry has flag 1 and holds `ret_tag`. A retire whose tag does not match leaves the entry unchanged.
- R8: When a rename write and a matching retire target the same register in one cycle, the rename write wins.
- R9: With `flush` high, every entry holds flag 0 after the edge. The rename group and the retires of that cycle are discarded.
- R10: Lookups in a cycle see the table as it stood before that cycle's retires and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Return all mappings to the committed file, discard this cycle's updates |
| in_valid | input | LANES | Lane holds an op, bit 0 is the oldest |
| in_dst_en | input | LANES | Op writes a destination register |
| in_dst_arch | input | LANES*AW | Destination register per lane |
| in_src0_arch | input | LANES*AW | First source register per lane |
| in_src1_arch | input | LANES*AW | Second source register per lane |
| alloc_base | input | TW | Reorder-buffer slot for the oldest valid lane |
| ret_valid | input | RET_PORTS | Retire port active |
| ret_arch | input | RET_PORTS*AW | Destination register of the retiring op |
| ret_tag | input | RET_PORTS*TW | Slot number of the retiring op |
| out_dst_tag | output | LANES*TW | Slot assigned to each lane's destination |
| out_src0_rob | output | LANES | First source pending in the reorder buffer (1) or committed (0) |
| out_src0_tag | output | LANES*TW | First source slot, meaningful when the flag is 1 |
| out_src1_rob | output | LANES | Second source location flag |
| out_src1_tag | output | LANES*TW | Second source slot, meaningful when the flag is 1 |

## Verification
The two functions that collide are a rename write and a retire revert. When they land on the same architectural register in the same clock, the revert must lose. A read of a register in the same cycle that it retires must still return the old slot. The bench provokes both deliberately: it retires a register with its current slot while a lane rewrites it or reads it. The bench judges the outcome by the lookup results in that cycle and in the following one. Random traffic chooses retire tags from the model's live mappings about half the time, so matching and stale retires both occur alongside renames and rare flushes.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int DEF_LANES     = 4;
  localparam int DEF_ARCH_REGS = 8;
  localparam int DEF_ROB_DEPTH = 64;
  localparam int DEF_RET_PORTS = 2;

  typedef enum logic {
    LOC_COMMITTED = 1'b0,
    LOC_PENDING   = 1'b1
  } loc_e;
endpackage

// File: rtl/rat_rst_sync.sv
module rat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rat_tag_alloc.sv
module rat_tag_alloc #(
  parameter int LANES = 4,
  parameter int TW    = 6
) (
  input  logic [LANES-1:0]         valid_i,
  input  logic [TW-1:0]            base_i,
  output logic [LANES-1:0][TW-1:0] tag_o
);
  logic [TW-1:0] run;

  // Slots are handed out consecutively to valid lanes only; wrap is natural
  always_comb begin
    run = base_i;
    for (int i = 0; i < LANES; i++) begin
      tag_o[i] = run;
      if (valid_i[i]) run = run + 1'b1;
    end
  end
endmodule

// File: rtl/rat_src_resolve.sv
module rat_src_resolve #(
  parameter int LANES     = 4,
  parameter int ARCH_REGS = 8,
  parameter int AW        = 3,
  parameter int TW        = 6
) (
  input  logic [LANES-1:0]             wr_en_i,
  input  logic [LANES-1:0][AW-1:0]     wr_arch_i,
  input  logic [LANES-1:0][TW-1:0]     wr_tag_i,
  input  logic [LANES-1:0][AW-1:0]     src_arch_i,
  input  logic [ARCH_REGS-1:0]         tbl_loc_i,
  input  logic [ARCH_REGS-1:0][TW-1:0] tbl_tag_i,
  output logic [LANES-1:0]             src_rob_o,
  output logic [LANES-1:0][TW-1:0]     src_tag_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          l_rob;
    logic [TW-1:0] l_tag;

    // Table value first, then older lanes in order; the youngest older writer wins
    always_comb begin
      l_rob = tbl_loc_i[src_arch_i[i]];
      l_tag = tbl_tag_i[src_arch_i[i]];
      for (int j = 0; j < i; j++) begin
        if (wr_en_i[j] && (wr_arch_i[j] == src_arch_i[i])) begin
          l_rob = rat_pkg::LOC_PENDING;
          l_tag = wr_tag_i[j];
        end
      end
    end

    assign src_rob_o[i] = l_rob;
    assign src_tag_o[i] = l_tag;
  end
endmodule

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int LANES     = 4,
  parameter int ARCH_REGS = 8,
  parameter int RET_PORTS = 2,
  parameter int AW        = 3,
  parameter int TW        = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic [LANES-1:0]             wr_en_i,
  input  logic [LANES-1:0][AW-1:0]     wr_arch_i,
  input  logic [LANES-1:0][TW-1:0]     wr_tag_i,
  input  logic [RET_PORTS-1:0]         ret_valid_i,
  input  logic [RET_PORTS-1:0][AW-1:0] ret_arch_i,
  input  logic [RET_PORTS-1:0][TW-1:0] ret_tag_i,
  output logic [ARCH_REGS-1:0]         loc_q,
  output logic [ARCH_REGS-1:0][TW-1:0] tag_q
);
  logic [ARCH_REGS-1:0]         loc_d;
  logic [ARCH_REGS-1:0][TW-1:0] tag_d;
  logic [ARCH_REGS-1:0]         tag_en;

  always_comb begin
    loc_d  = loc_q;
    tag_d  = tag_q;
    tag_en = '0;
    if (flush_i) begin
      loc_d = '0;
    end else begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        // Revert only while the entry still names the retiring slot
        for (int r = 0; r < RET_PORTS; r++) begin
          if (ret_valid_i[r] && (ret_arch_i[r] == AW'(a)) &&
              loc_q[a] && (tag_q[a] == ret_tag_i[r]))
            loc_d[a] = rat_pkg::LOC_COMMITTED;
        end
        // New mappings override reverts; the youngest lane is applied last
        for (int l = 0; l < LANES; l++) begin
          if (wr_en_i[l] && (wr_arch_i[l] == AW'(a))) begin
            loc_d[a]  = rat_pkg::LOC_PENDING;
            tag_d[a]  = wr_tag_i[l];
            tag_en[a] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      tag_q <= '0;
    end else begin
      loc_q <= loc_d;
      for (int a = 0; a < ARCH_REGS; a++) begin
        if (tag_en[a]) tag_q[a] <= tag_d[a];
      end
    end
  end
endmodule

// File: rtl/reg_alias_renamer.sv
module reg_alias_renamer #(
  parameter int LANES     = rat_pkg::DEF_LANES,
  parameter int ARCH_REGS = rat_pkg::DEF_ARCH_REGS,
  parameter int ROB_DEPTH = rat_pkg::DEF_ROB_DEPTH,
  parameter int RET_PORTS = rat_pkg::DEF_RET_PORTS,
  localparam int AW       = $clog2(ARCH_REGS),
  localparam int TW       = $clog2(ROB_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [LANES-1:0]        in_valid,
  input  logic [LANES-1:0]        in_dst_en,
  input  logic [LANES*AW-1:0]     in_dst_arch,
  input  logic [LANES*AW-1:0]     in_src0_arch,
  input  logic [LANES*AW-1:0]     in_src1_arch,
  input  logic [TW-1:0]           alloc_base,
  input  logic [RET_PORTS-1:0]    ret_valid,
  input  logic [RET_PORTS*AW-1:0] ret_arch,
  input  logic [RET_PORTS*TW-1:0] ret_tag,
  output logic [LANES*TW-1:0]     out_dst_tag,
  output logic [LANES-1:0]        out_src0_rob,
  output logic [LANES*TW-1:0]     out_src0_tag,
  output logic [LANES-1:0]        out_src1_rob,
  output logic [LANES*TW-1:0]     out_src1_tag
);
  logic                         rst_sync_n;
  logic [LANES-1:0]             wr_en;
  logic [LANES-1:0][AW-1:0]     dst_arch_v;
  logic [LANES-1:0][AW-1:0]     src0_arch_v;
  logic [LANES-1:0][AW-1:0]     src1_arch_v;
  logic [LANES-1:0][TW-1:0]     dst_tag_v;
  logic [LANES-1:0][TW-1:0]     src0_tag_v;
  logic [LANES-1:0][TW-1:0]     src1_tag_v;
  logic [RET_PORTS-1:0][AW-1:0] ret_arch_v;
  logic [RET_PORTS-1:0][TW-1:0] ret_tag_v;
  logic [ARCH_REGS-1:0]         tbl_loc;
  logic [ARCH_REGS-1:0][TW-1:0] tbl_tag;

  assign dst_arch_v  = in_dst_arch;
  assign src0_arch_v = in_src0_arch;
  assign src1_arch_v = in_src1_arch;
  assign ret_arch_v  = ret_arch;
  assign ret_tag_v   = ret_tag;
  assign wr_en       = in_valid & in_dst_en;

  rat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  rat_tag_alloc #(.LANES(LANES), .TW(TW)) u_alloc (
    .valid_i (in_valid),
    .base_i  (alloc_base),
    .tag_o   (dst_tag_v)
  );

  rat_map_table #(
    .LANES(LANES), .ARCH_REGS(ARCH_REGS), .RET_PORTS(RET_PORTS), .AW(AW), .TW(TW)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .flush_i     (flush),
    .wr_en_i     (wr_en),
    .wr_arch_i   (dst_arch_v),
    .wr_tag_i    (dst_tag_v),
    .ret_valid_i (ret_valid),
    .ret_arch_i  (ret_arch_v),
    .ret_tag_i   (ret_tag_v),
    .loc_q       (tbl_loc),
    .tag_q       (tbl_tag)
  );

  rat_src_resolve #(
    .LANES(LANES), .ARCH_REGS(ARCH_REGS), .AW(AW), .TW(TW)
  ) u_src0 (
    .wr_en_i    (wr_en),
    .wr_arch_i  (dst_arch_v),
    .wr_tag_i   (dst_tag_v),
    .src_arch_i (src0_arch_v),
    .tbl_loc_i  (tbl_loc),
    .tbl_tag_i  (tbl_tag),
    .src_rob_o  (out_src0_rob),
    .src_tag_o  (src0_tag_v)
  );

  rat_src_resolve #(
    .LANES(LANES), .ARCH_REGS(ARCH_REGS), .AW(AW), .TW(TW)
  ) u_src1 (
    .wr_en_i    (wr_en),
    .wr_arch_i  (dst_arch_v),
    .wr_tag_i   (dst_tag_v),
    .src_arch_i (src1_arch_v),
    .tbl_loc_i  (tbl_loc),
    .tbl_tag_i  (tbl_tag),
    .src_rob_o  (out_src1_rob),
    .src_tag_o  (src1_tag_v)
  );

  assign out_dst_tag  = dst_tag_v;
  assign out_src0_tag = src0_tag_v;
  assign out_src1_tag = src1_tag_v;
endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk #(
  parameter int LANES     = 4,
  parameter int ARCH_REGS = 8,
  parameter int RET_PORTS = 2,
  parameter int AW        = 3,
  parameter int TW        = 6
) (
  input logic                         clk,
  input logic                         rst_n_s,
  input logic                         flush,
  input logic [LANES-1:0]             in_valid,
  input logic [LANES-1:0]             in_dst_en,
  input logic [LANES-1:0][AW-1:0]     dst_arch,
  input logic [LANES-1:0][AW-1:0]     src0_arch,
  input logic [LANES-1:0][TW-1:0]     dst_tag,
  input logic [LANES-1:0]             src0_rob,
  input logic [RET_PORTS-1:0]         ret_valid,
  input logic [RET_PORTS-1:0][AW-1:0] ret_arch,
  input logic [RET_PORTS-1:0][TW-1:0] ret_tag,
  input logic [ARCH_REGS-1:0]         tbl_loc,
  input logic [ARCH_REGS-1:0][TW-1:0] tbl_tag
);
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> (tbl_loc == '0));

  // R2
  lane0_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid[0] |-> (src0_rob[0] == tbl_loc[src0_arch[0]]));

  for (genvar i = 0; i + 1 < LANES; i++) begin : g_adj
    // R3
    adjacent_tag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (in_valid[i] && in_valid[i+1]) |-> (dst_tag[i+1] == dst_tag[i] + 1'b1));
  end

  // R5
  youngest_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid[LANES-1] && in_dst_en[LANES-1] && !flush) |=>
      (tbl_loc[$past(dst_arch[LANES-1])] &&
       (tbl_tag[$past(dst_arch[LANES-1])] == $past(dst_tag[LANES-1]))));

  // R7
  retire_revert_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ret_valid[0] && (in_valid == '0) && !flush && tbl_loc[ret_arch[0]] &&
     (tbl_tag[ret_arch[0]] == ret_tag[0])) |=> !tbl_loc[$past(ret_arch[0])]);
endmodule

bind reg_alias_renamer rat_renamer_chk #(
  .LANES(LANES), .ARCH_REGS(ARCH_REGS), .RET_PORTS(RET_PORTS), .AW(AW), .TW(TW)
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_sync_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_dst_en (in_dst_en),
  .dst_arch  (dst_arch_v),
  .src0_arch (src0_arch_v),
  .dst_tag   (dst_tag_v),
  .src0_rob  (out_src0_rob),
  .ret_valid (ret_valid),
  .ret_arch  (ret_arch_v),
  .ret_tag   (ret_tag_v),
  .tbl_loc   (tbl_loc),
  .tbl_tag   (tbl_tag)
);

// File: tb/tb_reg_alias_renamer.sv
module tb_reg_alias_renamer;
  localparam int L  = 4;
  localparam int A  = 8;
  localparam int D  = 64;
  localparam int R  = 2;
  localparam int AW = 3;
  localparam int TW = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            flush;
  logic [L-1:0]    in_valid, in_dst_en;
  logic [L*AW-1:0] in_dst_arch, in_src0_arch, in_src1_arch;
  logic [TW-1:0]   alloc_base;
  logic [R-1:0]    ret_valid;
  logic [R*AW-1:0] ret_arch;
  logic [R*TW-1:0] ret_tag;
  logic [L*TW-1:0] out_dst_tag, out_src0_tag, out_src1_tag;
  logic [L-1:0]    out_src0_rob, out_src1_rob;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  bit  m_loc [A];
  int  m_tag [A];

  always #10 clk = ~clk;

  reg_alias_renamer #(.LANES(L), .ARCH_REGS(A), .ROB_DEPTH(D), .RET_PORTS(R)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_dst_en(in_dst_en), .in_dst_arch(in_dst_arch),
    .in_src0_arch(in_src0_arch), .in_src1_arch(in_src1_arch), .alloc_base(alloc_base),
    .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_tag(ret_tag),
    .out_dst_tag(out_dst_tag), .out_src0_rob(out_src0_rob), .out_src0_tag(out_src0_tag),
    .out_src1_rob(out_src1_rob), .out_src1_tag(out_src1_tag)
  );

  task automatic clear_inputs();
    flush = 0; in_valid = '0; in_dst_en = '0; in_dst_arch = '0;
    in_src0_arch = '0; in_src1_arch = '0; alloc_base = '0;
    ret_valid = '0; ret_arch = '0; ret_tag = '0;
  endtask

  task automatic set_op(int l, bit v, bit de, int dst, int s0, int s1);
    in_valid[l] = v; in_dst_en[l] = de;
    in_dst_arch[l*AW +: AW]  = AW'(dst);
    in_src0_arch[l*AW +: AW] = AW'(s0);
    in_src1_arch[l*AW +: AW] = AW'(s1);
  endtask

  task automatic set_ret(int p, bit v, int a, int t);
    ret_valid[p] = v;
    ret_arch[p*AW +: AW] = AW'(a);
    ret_tag[p*TW +: TW]  = TW'(t);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(int l, int src, int exp_tag[L], output bit loc, output int t);
    loc = m_loc[src]; t = m_tag[src];
    for (int j = 0; j < l; j++)
      if (in_valid[j] && in_dst_en[j] && int'(in_dst_arch[j*AW +: AW]) == src) begin
        loc = 1; t = exp_tag[j];
      end
  endtask

  // Inputs are set after a falling edge; compare, then advance the model at the rising edge
  task automatic step(string req);
    int exp_tag [L];
    int run;
    bit loc;
    int t;
    #1;
    run = int'(alloc_base);
    for (int l = 0; l < L; l++) begin
      exp_tag[l] = run;
      if (in_valid[l]) run = (run + 1) % D;
    end
    for (int l = 0; l < L; l++) begin
      if (!in_valid[l]) continue;
      check("R3", $sformatf("lane%0d dst tag", l), int'(out_dst_tag[l*TW +: TW]), exp_tag[l]);
      lookup(l, int'(in_src0_arch[l*AW +: AW]), exp_tag, loc, t);
      check(req, $sformatf("lane%0d src0 flag", l), int'(out_src0_rob[l]), int'(loc));
      if (loc) check(req, $sformatf("lane%0d src0 tag", l), int'(out_src0_tag[l*TW +: TW]), t);
      lookup(l, int'(in_src1_arch[l*AW +: AW]), exp_tag, loc, t);
      check(req, $sformatf("lane%0d src1 flag", l), int'(out_src1_rob[l]), int'(loc));
      if (loc) check(req, $sformatf("lane%0d src1 tag", l), int'(out_src1_tag[l*TW +: TW]), t);
    end
    @(posedge clk);
    if (flush) begin
      for (int a = 0; a < A; a++) m_loc[a] = 0;
    end else begin
      bit nloc [A];
      for (int a = 0; a < A; a++) nloc[a] = m_loc[a];
      for (int p = 0; p < R; p++) begin
        int ra = int'(ret_arch[p*AW +: AW]);
        if (ret_valid[p] && m_loc[ra] && m_tag[ra] == int'(ret_tag[p*TW +: TW])) nloc[ra] = 0;
      end
      for (int l = 0; l < L; l++)
        if (in_valid[l] && in_dst_en[l]) begin
          nloc[int'(in_dst_arch[l*AW +: AW])] = 1;
          m_tag[int'(in_dst_arch[l*AW +: AW])] = exp_tag[l];
        end
      for (int a = 0; a < A; a++) m_loc[a] = nloc[a];
    end
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic read_all(string req);
    for (int l = 0; l < L; l++) set_op(l, 1, 0, 0, 2*l, 2*l + 1);
    step(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < A; a++) begin m_loc[a] = 0; m_tag[a] = 0; end
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: every register reads as committed after reset
    read_all("R1");

    // R4: add takes slot 37, following subtract takes 38 and reads 37
    alloc_base = 37;
    set_op(0, 1, 1, 0, 0, 1);
    set_op(1, 1, 1, 0, 0, 2);
    set_op(2, 1, 0, 0, 0, 0);
    step("R4");

    // R5: the later group sees the youngest writer; R4 again inside the group
    alloc_base = 39;
    set_op(0, 1, 0, 0, 0, 1);
    set_op(1, 1, 1, 0, 3, 0);
    set_op(2, 1, 1, 3, 0, 3);
    set_op(3, 1, 1, 0, 0, 3);
    step("R5");

    // R3: slot numbering wraps past the last reorder-buffer slot
    alloc_base = 62;
    for (int l = 0; l < L; l++) set_op(l, 1, 1, l + 1, 1, l);
    step("R3");
    // R3: an invalid lane consumes no slot
    alloc_base = 10;
    set_op(0, 1, 1, 6, 6, 6);
    set_op(1, 0, 1, 7, 6, 6);
    set_op(2, 1, 1, 5, 6, 6);
    set_op(3, 1, 0, 0, 5, 6);
    step("R3");

    // R6: destination-disabled and invalid lanes neither bypass nor update
    flush = 1;
    step("R9");
    alloc_base = 20;
    set_op(0, 1, 0, 5, 0, 0);
    set_op(1, 1, 1, 6, 5, 7);
    set_op(2, 0, 1, 7, 0, 0);
    set_op(3, 1, 0, 0, 7, 5);
    step("R6");
    read_all("R6");

    // R7: stale tag ignored, then matching tag reverts
    set_ret(0, 1, 6, 3);
    step("R7");
    read_all("R7");
    set_ret(1, 1, 6, m_tag[6]);
    step("R7");
    read_all("R7");

    // R8: rename and matching retire on the same register in one cycle
    alloc_base = 30;
    set_op(0, 1, 1, 1, 0, 0);
    step("R8");
    alloc_base = 31;
    set_op(0, 1, 1, 1, 0, 0);
    set_ret(0, 1, 1, 30);
    step("R8");
    read_all("R8");

    // R10: a read in the cycle of a matching retire still sees the slot
    set_op(0, 1, 0, 0, 1, 1);
    set_ret(0, 1, 1, 31);
    step("R10");
    read_all("R10");

    // R9: flush discards the group and retires of its cycle
    alloc_base = 50;
    for (int l = 0; l < L; l++) set_op(l, 1, 1, l + 2, l, l + 4);
    step("R9");
    alloc_base = 54;
    set_op(0, 1, 1, 3, 0, 0);
    set_ret(0, 1, 2, 50);
    flush = 1;
    step("R9");
    read_all("R9");

    // R2: random traffic, retire tags drawn from live mappings half the time
    begin
      int base = 0;
      for (int c = 0; c < 3000; c++) begin
        int nv = 0;
        for (int l = 0; l < L; l++) begin
          set_op(l, ($urandom % 4) != 0, ($urandom % 3) != 0,
                 $urandom % A, $urandom % A, $urandom % A);
          if (in_valid[l]) nv++;
        end
        alloc_base = TW'(base);
        base = (base + nv) % D;
        for (int p = 0; p < R; p++) begin
          int ra = $urandom % A;
          set_ret(p, ($urandom % 2) != 0, ra, ($urandom % 2) ? m_tag[ra] : $urandom % D);
        end
        flush = (($urandom % 64) == 0);
        step("R2");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule